// File: doc/BRIEF.md
# Masked Wavefront Lane Executor

This block runs one vector integer operation across a 64-lane wavefront on a datapath only 16 lanes wide. An accepted issue captures both source operand sets, the opcode and the current execution mask. The block then sweeps the wavefront in four consecutive quarter passes. Each lane whose captured mask bit is set receives its result. Every other lane keeps the destination value it already held. All four passes always run, including when the mask is entirely clear.

Next to the datapath sits a mask unit for structured branches. A small stack saves the mask on branch entry, and the mask is then loaded from a per-lane condition. For the else-part, the mask becomes the saved entry mask with the condition lanes removed. On exit, the saved mask is restored. A registered zero flag, updated on the same edge as the mask, lets an outside sequencer skip a branch body whose mask is empty. Wave-wide any-true and all-true queries come straight from the mask.

Top module: `wave_lane_exec`

## Requirements
- R1: An issue accepted while idle raises busy for exactly 4 cycles, one per 16-lane quarter (lanes 0-15 first, then 16-31, 32-47, 48-63). Done is high for the single cycle after the last quarter is written back.
- R2: Opcode encodings: 0 add, 1 subtract (a minus b), 2 bitwise and, 3 bitwise or, 4 bitwise xor, 5 copy a. Codes 6 and 7 also copy a. Arithmetic wraps modulo 2^32.
- R3: A lane whose mask bit is 0 keeps its previous destination value, and a lane whose bit is 1 takes the result. The destination vector is all zero after reset.
- R4: The mask used by an operation is the one present when the issue was accepted. Mask commands given while the passes run change the mask output but not that operation.
- R5: An issue presented while busy is ignored: no extra passes run and the destination is not written by it.
- R6: After reset the mask is all ones, the zero flag and the error flag are 0, and the save stack is empty.
- R7: Mask command encodings: 0 none; 1 enter (push mask, then mask = condition); 2 else (mask = saved top AND NOT mask); 3 exit (mask = saved top, pop); 4 load (mask = condition, no push).
- R8: The zero flag equals (mask == 0) and changes on the same edge as the mask.
- R9: Any-true is (mask != 0). All-true is (inverted mask == 0).
- R10: The save stack holds 2 masks, so one branch can nest inside another. Enter with a full stack, or else/exit with an empty stack, sets a sticky error flag and leaves the mask and stack unchanged.
- R11: With an all-zero captured mask, the 4 passes and the done pulse still occur and the destination is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | Request to start a vector operation |
| opcode | input | 3 | Operation code, sampled with issue |
| src_a | input | 2048 | First operand vector, lane i at bits 32i+31:32i |
| src_b | input | 2048 | Second operand vector, same layout |
| mask_cmd | input | 3 | Mask command |
| cond_mask | input | 64 | Per-lane condition for enter and load |
| dst_out | output | 2048 | Destination vector |
| exec_mask | output | 64 | Current execution mask |
| mask_zero | output | 1 | Mask is all zero |
| any_true | output | 1 | At least one lane active |
| all_true | output | 1 | Every lane active |
| busy | output | 1 | Quarter passes in progress |
| done | output | 1 | One-cycle pulse after the last writeback |
| stack_err | output | 1 | Sticky save-stack overflow or underflow |

## Verification
A mask command and a running vector operation can act in the same cycle, because the mask unit keeps accepting commands while the quarter passes proceed. The bench sends enter, else, exit and load commands during the second busy cycle. It then checks two things: every lane of the destination follows the mask present at issue, and the mask output follows the new command. A second issue is also presented during the passes, and the bench confirms that no fifth pass or second done pulse appears.

// File: rtl/wlx_pkg.sv
// Shared encodings for the wavefront lane executor.
package wlx_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_MOV = 3'd5
    } vop_t;

    typedef enum logic [2:0] {
        MC_NONE  = 3'd0,
        MC_ENTER = 3'd1,
        MC_ELSE  = 3'd2,
        MC_EXIT  = 3'd3,
        MC_LOAD  = 3'd4
    } mcmd_t;
endpackage

// File: rtl/wlx_lane_alu.sv
// One integer lane of the vector datapath.
// Purely combinational; any code outside the defined set copies operand a.
module wlx_lane_alu
    import wlx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [2:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    // Select the lane result from the opcode.
    always_comb begin
        case (vop_t'(op))
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/wlx_pass_seq.sv
// Quarter-pass sequencer: on an accepted issue it steps through PASSES passes,
// holding busy, then pulses done. Assumes issue while busy is to be dropped.
module wlx_pass_seq #(
    parameter int PASSES = 4,
    localparam int PW = (PASSES > 1) ? $clog2(PASSES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    output logic          start,
    output logic          busy,
    output logic [PW-1:0] pass,
    output logic          done
);
    localparam logic [PW-1:0] LAST = PW'(PASSES - 1);

    // Issue is accepted only while idle.
    assign start = issue && !busy;

    // Advance the pass counter and raise done after the final pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            pass <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                pass <= '0;
            end else if (busy) begin
                if (pass == LAST) begin
                    busy <= 1'b0;
                    pass <= '0;
                    done <= 1'b1;
                end else begin
                    pass <= pass + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wlx_mask_unit.sv
// Execution mask register with a save stack for structured branches.
// Assumes one command per cycle; faulting commands leave all state unchanged
// except for the sticky error flag.
module wlx_mask_unit
    import wlx_pkg::*;
#(
    parameter int WAVE  = 64,
    parameter int DEPTH = 2,
    localparam int SPW = $clog2(DEPTH + 1),
    localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      cmd,
    input  logic [WAVE-1:0] cond,
    output logic [WAVE-1:0] exec,
    output logic            zero,
    output logic            err
);
    logic [WAVE-1:0] stk [DEPTH];
    logic [SPW-1:0]  sp;
    logic [WAVE-1:0] top;
    logic [WAVE-1:0] nxt;
    logic            push, pop, fault;

    // Saved mask at the top of the stack, zero when empty.
    assign top = (sp != '0) ? stk[IW'(sp - 1'b1)] : '0;

    // Decode the command into the next mask and stack motion.
    always_comb begin
        nxt   = exec;
        push  = 1'b0;
        pop   = 1'b0;
        fault = 1'b0;
        case (mcmd_t'(cmd))
            MC_ENTER: begin
                if (sp == SPW'(DEPTH)) fault = 1'b1;
                else begin
                    push = 1'b1;
                    nxt  = cond;
                end
            end
            MC_ELSE: begin
                if (sp == '0) fault = 1'b1;
                else nxt = top & ~exec;
            end
            MC_EXIT: begin
                if (sp == '0) fault = 1'b1;
                else begin
                    pop = 1'b1;
                    nxt = top;
                end
            end
            MC_LOAD: nxt = cond;
            default: nxt = exec;
        endcase
    end

    // Update the mask, zero flag, error flag and stack pointer together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec <= '1;
            zero <= 1'b0;
            err  <= 1'b0;
            sp   <= '0;
        end else begin
            exec <= nxt;
            zero <= (nxt == '0);
            err  <= err | fault;
            if (push)     sp <= sp + 1'b1;
            else if (pop) sp <= sp - 1'b1;
        end
    end

    // Stack storage: a push writes the outgoing mask at the current pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
        end else if (push) begin
            stk[IW'(sp)] <= exec;
        end
    end
endmodule

// File: rtl/wave_lane_exec.sv
// Masked wavefront executor top. Latches operands, opcode and mask on an
// accepted issue, then writes one SIMD-wide quarter of lanes per cycle.
// Assumes lane i of a vector sits at bits DW*i+DW-1 : DW*i.
module wave_lane_exec
    import wlx_pkg::*;
#(
    parameter int WAVE  = 64,
    parameter int SIMD  = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 2,
    localparam int PASSES = WAVE / SIMD,
    localparam int PW     = (PASSES > 1) ? $clog2(PASSES) : 1,
    localparam int QW     = SIMD * DW,
    localparam int VW     = WAVE * DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic [2:0]      opcode,
    input  logic [VW-1:0]   src_a,
    input  logic [VW-1:0]   src_b,
    input  logic [2:0]      mask_cmd,
    input  logic [WAVE-1:0] cond_mask,
    output logic [VW-1:0]   dst_out,
    output logic [WAVE-1:0] exec_mask,
    output logic            mask_zero,
    output logic            any_true,
    output logic            all_true,
    output logic            busy,
    output logic            done,
    output logic            stack_err
);
    logic            start;
    logic [PW-1:0]   pass;
    logic [VW-1:0]   a_lat, b_lat;
    logic [2:0]      op_lat;
    logic [WAVE-1:0] m_lat;
    logic [QW-1:0]   qa, qb, qy;

    wlx_pass_seq #(.PASSES(PASSES)) seq_i (
        .clk(clk), .rst_n(rst_n), .issue(issue),
        .start(start), .busy(busy), .pass(pass), .done(done)
    );

    wlx_mask_unit #(.WAVE(WAVE), .DEPTH(DEPTH)) mask_i (
        .clk(clk), .rst_n(rst_n), .cmd(mask_cmd), .cond(cond_mask),
        .exec(exec_mask), .zero(mask_zero), .err(stack_err)
    );

    // Wave-wide queries taken from the live mask.
    assign any_true = |exec_mask;
    assign all_true = (~exec_mask == '0);

    // Capture the operation context when an issue is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_lat  <= '0;
            b_lat  <= '0;
            op_lat <= '0;
            m_lat  <= '0;
        end else if (start) begin
            a_lat  <= src_a;
            b_lat  <= src_b;
            op_lat <= opcode;
            m_lat  <= exec_mask;
        end
    end

    // Select the quarter of the operands handled in this pass.
    assign qa = a_lat[pass*QW +: QW];
    assign qb = b_lat[pass*QW +: QW];

    // One ALU per physical SIMD lane.
    for (genvar g = 0; g < SIMD; g++) begin : g_lane
        wlx_lane_alu #(.DW(DW)) alu_i (
            .op(op_lat),
            .a(qa[g*DW +: DW]),
            .b(qb[g*DW +: DW]),
            .y(qy[g*DW +: DW])
        );
    end

    // Write back active lanes of the current quarter; others hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_out <= '0;
        end else if (busy) begin
            for (int l = 0; l < WAVE; l++) begin
                if (pass == PW'(l / SIMD) && m_lat[l])
                    dst_out[l*DW +: DW] <= qy[(l % SIMD)*DW +: DW];
            end
        end
    end
endmodule

// File: rtl/wlx_exec_checker.sv
// Protocol and mask-consistency checks for wave_lane_exec.
module wlx_exec_checker #(
    parameter int WAVE   = 64,
    parameter int VW     = 2048,
    parameter int PASSES = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue,
    input logic [VW-1:0]   dst_out,
    input logic [WAVE-1:0] exec_mask,
    input logic            mask_zero,
    input logic            any_true,
    input logic            all_true,
    input logic            busy,
    input logic            done,
    input logic            stack_err
);
    localparam int CW = $clog2(PASSES + 1) + 1;
    logic [CW-1:0] run;

    // Count consecutive busy cycles seen so far.
    always_ff @(posedge clk) begin
        if (!rst_n) run <= '0;
        else        run <= busy ? run + 1'b1 : '0;
    end

    AST_BUSY_LEN:   assert property (@(posedge clk) disable iff (!rst_n) busy |-> run < CW'(PASSES));            // R1
    AST_DONE_AFTER: assert property (@(posedge clk) disable iff (!rst_n) done |-> (run == CW'(PASSES)) && !busy); // R1
    AST_ISSUE_GO:   assert property (@(posedge clk) disable iff (!rst_n) (issue && !busy) |=> busy);              // R1
    AST_IDLE_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) !busy |=> $stable(dst_out));             // R3
    AST_ZERO_FLAG:  assert property (@(posedge clk) disable iff (!rst_n) mask_zero == (exec_mask == '0));         // R8
    AST_ANY_TRUE:   assert property (@(posedge clk) disable iff (!rst_n) any_true == !mask_zero);                 // R9
    AST_ALL_TRUE:   assert property (@(posedge clk) disable iff (!rst_n) all_true |-> !mask_zero);                // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) stack_err |=> stack_err);                // R10
endmodule

bind wave_lane_exec wlx_exec_checker #(.WAVE(WAVE), .VW(VW), .PASSES(PASSES)) chk_i (
    .clk(clk), .rst_n(rst_n), .issue(issue), .dst_out(dst_out),
    .exec_mask(exec_mask), .mask_zero(mask_zero), .any_true(any_true),
    .all_true(all_true), .busy(busy), .done(done), .stack_err(stack_err)
);

// File: tb/wave_lane_exec_tb_top.sv
// Self-checking bench: directed branch and pass corner cases plus a
// seeded random mix of operations and mask commands.
module wave_lane_exec_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WAVE = 64;
    localparam int DW   = 32;
    localparam int VW   = WAVE * DW;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            issue;
    logic [2:0]      opcode;
    logic [VW-1:0]   src_a, src_b;
    logic [2:0]      mask_cmd;
    logic [WAVE-1:0] cond_mask;
    logic [VW-1:0]   dst_out;
    logic [WAVE-1:0] exec_mask;
    logic            mask_zero, any_true, all_true, busy, done, stack_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [DW-1:0]   e_dst [WAVE];
    logic [WAVE-1:0] e_exec;
    logic [WAVE-1:0] e_stk [2];
    int              e_sp;
    logic            e_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    wave_lane_exec dut_i (
        .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode),
        .src_a(src_a), .src_b(src_b), .mask_cmd(mask_cmd), .cond_mask(cond_mask),
        .dst_out(dst_out), .exec_mask(exec_mask), .mask_zero(mask_zero),
        .any_true(any_true), .all_true(all_true), .busy(busy), .done(done),
        .stack_err(stack_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ref_alu(input logic [2:0] op,
                                               input logic [DW-1:0] a, input logic [DW-1:0] b);
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            default: return a;
        endcase
    endfunction

    // Mask command model (R7, R10).
    task automatic model_cmd(input logic [2:0] c, input logic [WAVE-1:0] cnd);
        case (c)
            3'd1: if (e_sp == 2) e_err = 1; else begin e_stk[e_sp] = e_exec; e_sp++; e_exec = cnd; end
            3'd2: if (e_sp == 0) e_err = 1; else e_exec = e_stk[e_sp-1] & ~e_exec;
            3'd3: if (e_sp == 0) e_err = 1; else begin e_exec = e_stk[e_sp-1]; e_sp--; end
            3'd4: e_exec = cnd;
            default: ;
        endcase
    endtask

    task automatic check_mask(input string req);
        check(exec_mask == e_exec, req, "mask", exec_mask, e_exec);
        check(mask_zero == (e_exec == 0), "R8", "zero flag", 64'(mask_zero), 64'(e_exec == 0));
        check(any_true == (e_exec != 0), "R9", "any_true", 64'(any_true), 64'(e_exec != 0));
        check(all_true == (e_exec == '1), "R9", "all_true", 64'(all_true), 64'(e_exec == '1));
        check(stack_err == e_err, "R10", "error flag", 64'(stack_err), 64'(e_err));
    endtask

    task automatic check_dst(input string req);
        int bad = -1;
        for (int l = 0; l < WAVE; l++)
            if (bad < 0 && dst_out[l*DW +: DW] !== e_dst[l]) bad = l;
        if (bad < 0) check(1, req, "dst", 0, 0);
        else check(0, req, $sformatf("dst lane %0d", bad),
                   64'(dst_out[bad*DW +: DW]), 64'(e_dst[bad]));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; issue = 0; opcode = 0; mask_cmd = 0; cond_mask = 0;
        src_a = '0; src_b = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        e_exec = '1; e_sp = 0; e_err = 0;
        for (int l = 0; l < WAVE; l++) e_dst[l] = '0;
    endtask

    task automatic do_cmd(input logic [2:0] c, input logic [WAVE-1:0] cnd, input string req);
        mask_cmd = c; cond_mask = cnd;
        @(negedge clk);
        mask_cmd = 0;
        model_cmd(c, cnd);
        check_mask(req);
    endtask

    // Run one vector op; optional mask command and extra issue during passes.
    task automatic run_op(input logic [2:0] op, input logic [VW-1:0] a, input logic [VW-1:0] b,
                          input logic [2:0] mid_c, input logic [WAVE-1:0] mid_cnd,
                          input bit extra, input string req);
        logic [WAVE-1:0] snap = e_exec;
        int n = 0;
        for (int l = 0; l < WAVE; l++)
            if (snap[l]) e_dst[l] = ref_alu(op, a[l*DW +: DW], b[l*DW +: DW]);
        opcode = op; src_a = a; src_b = b; issue = 1;
        @(negedge clk);
        issue = 0;
        while (busy && n < 10) begin
            n++;
            if (n == 1) begin
                mask_cmd = mid_c; cond_mask = mid_cnd;
                if (extra) begin issue = 1; opcode = 3'd4; src_a = ~a; end
            end
            if (n == 2) begin
                mask_cmd = 0; issue = 0;
                model_cmd(mid_c, mid_cnd);
            end
            @(negedge clk);
        end
        check(n == 4, "R1", "busy cycles", 64'(n), 64'd4);
        check(done == 1, "R1", "done pulse", 64'(done), 64'd1);
        check_dst(req);
        if (mid_c != 0) check_mask("R4");
        @(negedge clk);
        check(done == 0 && busy == 0, extra ? "R5" : "R1", "idle after done",
              64'({busy, done}), 64'd0);
        check_dst(extra ? "R5" : req);
    endtask

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int l = 0; l < WAVE; l++) v[l*DW +: DW] = $urandom;
        return v;
    endfunction

    function automatic logic [WAVE-1:0] rnd_mask();
        return {$urandom, $urandom};
    endfunction

    initial begin
        void'($urandom(32'h5EED_0042));
        do_reset();
        @(negedge clk);
        // R6 reset state
        check_mask("R6");
        check(busy == 0 && done == 0, "R6", "idle after reset", 64'({busy, done}), 0);
        check_dst("R3");

        // R2 all opcodes with full mask, including codes 6 and 7
        for (int op = 0; op < 8; op++)
            run_op(3'(op), rnd_vec(), rnd_vec(), 3'd0, '0, 0, "R2");
        // R2 wraparound
        run_op(3'd0, {WAVE{32'hFFFF_FFFF}}, {WAVE{32'h0000_0002}}, 3'd0, '0, 0, "R2");
        run_op(3'd1, {WAVE{32'h0000_0001}}, {WAVE{32'h0000_0003}}, 3'd0, '0, 0, "R2");

        // R3 partial mask via load
        do_cmd(3'd4, 64'hF0F0_0000_FFFF_8001, "R7");
        run_op(3'd0, rnd_vec(), rnd_vec(), 3'd0, '0, 0, "R3");

        // R11 all-zero mask still runs 4 passes, destination unchanged
        do_cmd(3'd4, '0, "R8");
        run_op(3'd5, rnd_vec(), rnd_vec(), 3'd0, '0, 0, "R11");

        // R7 branch sequence: enter, else, exit
        do_cmd(3'd4, 64'h00FF_FF00_FFFF_0000, "R7");
        do_cmd(3'd1, 64'h0F0F_0F0F_0F0F_0F0F, "R7");
        run_op(3'd4, rnd_vec(), rnd_vec(), 3'd0, '0, 0, "R3");
        do_cmd(3'd2, '0, "R7");
        run_op(3'd3, rnd_vec(), rnd_vec(), 3'd0, '0, 0, "R3");
        do_cmd(3'd3, '0, "R7");
        // else yielding zero mask when all entry lanes took the if-part
        do_cmd(3'd1, 64'h00FF_FF00_FFFF_0000, "R7");
        do_cmd(3'd2, '0, "R8");

        // R10 nesting to depth 2 then overflow
        do_cmd(3'd1, 64'h1, "R10");
        do_cmd(3'd1, 64'h2, "R10");
        do_reset();
        do_cmd(3'd1, 64'hAA, "R10");
        do_cmd(3'd1, 64'h0A, "R10");
        do_cmd(3'd1, 64'h02, "R10");
        do_cmd(3'd3, '0, "R10");
        do_cmd(3'd3, '0, "R10");
        // underflow
        do_reset();
        do_cmd(3'd3, '0, "R10");
        do_cmd(3'd2, '0, "R10");

        // R4 and R5: mask commands and issue during passes
        do_reset();
        @(negedge clk);
        do_cmd(3'd4, 64'hCAFE_F00D_1234_5678, "R7");
        run_op(3'd0, rnd_vec(), rnd_vec(), 3'd1, 64'h0000_FFFF_0000_FFFF, 0, "R4");
        run_op(3'd1, rnd_vec(), rnd_vec(), 3'd2, '0, 1, "R4");
        run_op(3'd2, rnd_vec(), rnd_vec(), 3'd3, '0, 1, "R4");

        // Random mix
        for (int it = 0; it < 60; it++) begin
            logic [2:0] c = 3'($urandom_range(0, 4));
            if ($urandom_range(0, 2) == 0)
                run_op(3'($urandom_range(0, 7)), rnd_vec(), rnd_vec(), c, rnd_mask(),
                       $urandom_range(0, 1) == 1, "R4");
            else
                do_cmd(c, rnd_mask(), "R7");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule